// File: doc/BRIEF.md
# Watchdog Control Register with Per-Bit Write Locking

This block holds the 16-bit control register of a watchdog timer on a simple 32-bit peripheral bus. Each bit follows its own write rule. The three stop-configuration bits keep only the first value written after reset. The enable bit can be raised once and then stays high until reset. The timeout byte can be rewritten at any time. The effect of these rules can only be undone by reset, so a boot routine has exactly one chance to commit the configuration.

The bus carries byte enables for four lanes and a half-word select. The register sits in the lower half-word. A full 32-bit access does not fault. It is folded onto the lower half-word, and the upper lanes are dropped. Any access that does not reach the lower lanes is answered with a bus error and has no effect.

A small down-counter stands in for the watchdog proper so that the enable bit and the timeout byte have a visible effect. While enabled it counts down from the timeout byte. When it expires it pulses a timeout output for one cycle and reloads. A service input reloads it early.

Top module: `wd_ctrl_lock`

## Requirements
- R1: After reset the register reads 0xFF00, and every output (enable, the three stop bits, timeout pulse) is 0.
- R2: Bit 2 (enable) is set-only: writing 1 through lane 0 sets it, and writing 0 never clears it before reset.
- R3: Bits 0 (wait stop), 1 (debug stop) and 3 (low-power stop) take the value of the first write after reset whose byte enable covers lane 0. Every later write is ignored, even when that first write left the value unchanged, as in a read-modify-write.
- R4: Bits 15:8 (timeout) can be written freely through lane 1. A write that does not enable lane 0 consumes no first-write chance.
- R5: An access with the half-word select at 0 and all four byte enables set raises no bus error. It acts as a 16-bit access on lanes 1:0, and reads return 0 in bits 31:16. Bits 7:4 always read 0.
- R6: An access with the half-word select at 1, or with neither lane 0 nor lane 1 enabled, raises the bus error in the same cycle, returns read data 0 and changes no register bit.
- R7: While enabled, the timeout output pulses for one cycle every timeout+1 cycles. While disabled it never pulses.
- R8: A service strobe reloads the counter and wins over an expiry in the same cycle, so that no pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Bus access present this cycle |
| busWrite | input | 1 | 1 for write, 0 for read |
| busHalfSel | input | 1 | Selects the upper half-word of the 32-bit window |
| busByteEn | input | 4 | Byte lane enables |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the access cycle |
| busError | output | 1 | Access rejected, same cycle |
| wdKick | input | 1 | Service strobe that reloads the counter |
| wdEnable | output | 1 | Watchdog enable |
| cfgWaitStop | output | 1 | Stop counting in wait mode |
| cfgDebugStop | output | 1 | Stop counting in debug mode |
| cfgLowPwrStop | output | 1 | Stop counting in low-power mode |
| timeoutPulse | output | 1 | One-cycle expiry pulse |

## Verification
Two pairs of functions can meet in one cycle. In the first, a service strobe arrives in the exact cycle the counter sits at zero. The bench drives the strobe on that edge, counted from the enabling write. It expects no pulse there and the next pulse one full period later. In the second, a write arrives on a lane whose first-write flag is already spent. The bench sweeps every ordered pair of low-nibble values under three access sizes, and checks that the stop bits keep the first value while the enable bit takes the OR of both writes.

// File: rtl/wd_lock_pkg.sv
`timescale 1ns/1ps
package wd_lock_pkg;
  localparam int REG_W   = 16;
  localparam int LANES   = REG_W / 8;
  localparam int WAIT_BIT = 0;
  localparam int DBG_BIT  = 1;
  localparam int EN_BIT   = 2;
  localparam int LP_BIT   = 3;
  localparam int TO_LSB   = 8;
  localparam int TO_W     = REG_W - TO_LSB;

  typedef enum logic [1:0] {
    RULE_RSVD, RULE_FREE, RULE_ONCE, RULE_SETONLY
  } bitRule_e;

  function automatic bitRule_e ruleOf(input int idx);
    if (idx == EN_BIT) return RULE_SETONLY;
    if (idx == WAIT_BIT || idx == DBG_BIT || idx == LP_BIT) return RULE_ONCE;
    if (idx >= TO_LSB) return RULE_FREE;
    return RULE_RSVD;
  endfunction

  typedef struct packed {
    logic [LANES-1:0] laneWr;
    logic             rdEn;
    logic             err;
  } busStrobe_t;
endpackage

// File: rtl/wd_lock_ctrl.sv
`timescale 1ns/1ps
module wd_lock_ctrl
  import wd_lock_pkg::*;
(
  input  logic             busValid,
  input  logic             busWrite,
  input  logic             busHalfSel,
  input  logic [LANES-1:0] lowLanes,
  output busStrobe_t       strobes
);
  logic hit;

  // Upper lanes never reach the register: a wide access folds to lanes 1:0.
  assign hit = busValid && !busHalfSel && (|lowLanes);

  always_comb begin
    strobes        = '0;
    strobes.err    = busValid && !hit;
    strobes.rdEn   = hit && !busWrite;
    strobes.laneWr = (hit && busWrite) ? lowLanes : '0;
  end
endmodule

// File: rtl/wd_lock_regs.sv
`timescale 1ns/1ps
module wd_lock_regs
  import wd_lock_pkg::*;
#(
  parameter logic [TO_W-1:0] RST_TIMEOUT = '1
)(
  input  logic             clk,
  input  logic             rstN,
  input  busStrobe_t       strobes,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] regVal
);
  localparam logic [REG_W-1:0] RST_REG = REG_W'(RST_TIMEOUT) << TO_LSB;

  for (genvar i = 0; i < REG_W; i++) begin : g_bit
    localparam bitRule_e RULE = ruleOf(i);
    localparam int       LANE = i / 8;
    if (RULE == RULE_ONCE) begin : g_once
      logic valQ, doneQ;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          valQ  <= RST_REG[i];
          doneQ <= 1'b0;
        end else if (strobes.laneWr[LANE] && !doneQ) begin
          valQ  <= wrData[i];
          doneQ <= 1'b1;
        end
      end
      assign regVal[i] = valQ;
    end else if (RULE == RULE_SETONLY) begin : g_set
      logic valQ;
      always_ff @(posedge clk) begin
        if (!rstN)                                   valQ <= RST_REG[i];
        else if (strobes.laneWr[LANE] && wrData[i])  valQ <= 1'b1;
      end
      assign regVal[i] = valQ;
    end else if (RULE == RULE_FREE) begin : g_free
      logic valQ;
      always_ff @(posedge clk) begin
        if (!rstN)                       valQ <= RST_REG[i];
        else if (strobes.laneWr[LANE])   valQ <= wrData[i];
      end
      assign regVal[i] = valQ;
    end else begin : g_rsvd
      logic unusedBit;
      assign unusedBit = wrData[i];
      assign regVal[i] = 1'b0;
    end
  end
endmodule

// File: rtl/wd_lock_counter.sv
`timescale 1ns/1ps
module wd_lock_counter #(
  parameter int CNT_W = 8
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             kick,
  input  logic [CNT_W-1:0] reload,
  output logic             pulse
);
  logic [CNT_W-1:0] cntQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ  <= '0;
      pulse <= 1'b0;
    end else begin
      pulse <= 1'b0;
      if (!enable || kick) begin
        cntQ <= reload;
      end else if (cntQ == '0) begin
        cntQ  <= reload;
        pulse <= 1'b1;
      end else begin
        cntQ <= cntQ - 1'b1;
      end
    end
  end
endmodule

// File: rtl/wd_ctrl_lock.sv
`timescale 1ns/1ps
module wd_ctrl_lock
  import wd_lock_pkg::*;
#(
  parameter int              DATA_W      = 32,
  parameter logic [TO_W-1:0] RST_TIMEOUT = '1
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic              busHalfSel,
  input  logic [DATA_W/8-1:0] busByteEn,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              busError,
  input  logic              wdKick,
  output logic              wdEnable,
  output logic              cfgWaitStop,
  output logic              cfgDebugStop,
  output logic              cfgLowPwrStop,
  output logic              timeoutPulse
);
  busStrobe_t       strobes;
  logic [REG_W-1:0] regVal;
  logic             unusedBits;

  assign unusedBits = ^{busWdata[DATA_W-1:REG_W], busByteEn[DATA_W/8-1:LANES]};

  wd_lock_ctrl u_ctrl (
    .busValid  (busValid),
    .busWrite  (busWrite),
    .busHalfSel(busHalfSel),
    .lowLanes  (busByteEn[LANES-1:0]),
    .strobes   (strobes)
  );

  wd_lock_regs #(.RST_TIMEOUT(RST_TIMEOUT)) u_regs (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .wrData (busWdata[REG_W-1:0]),
    .regVal (regVal)
  );

  wd_lock_counter #(.CNT_W(TO_W)) u_cnt (
    .clk   (clk),
    .rstN  (rstN),
    .enable(regVal[EN_BIT]),
    .kick  (wdKick),
    .reload(regVal[REG_W-1:TO_LSB]),
    .pulse (timeoutPulse)
  );

  assign busRdata      = strobes.rdEn ? DATA_W'(regVal) : '0;
  assign busError      = strobes.err;
  assign wdEnable      = regVal[EN_BIT];
  assign cfgWaitStop   = regVal[WAIT_BIT];
  assign cfgDebugStop  = regVal[DBG_BIT];
  assign cfgLowPwrStop = regVal[LP_BIT];
endmodule

// File: rtl/wd_ctrl_lock_chk.sv
`timescale 1ns/1ps
module wd_ctrl_lock_chk (
  input logic        clk,
  input logic        rstN,
  input logic        busValid,
  input logic        busWrite,
  input logic        busHalfSel,
  input logic [3:0]  busByteEn,
  input logic [31:0] busRdata,
  input logic        busError,
  input logic        wdKick,
  input logic        wdEnable,
  input logic        cfgWaitStop,
  input logic        cfgDebugStop,
  input logic        cfgLowPwrStop,
  input logic        timeoutPulse
);
  logic seenLo;
  always_ff @(posedge clk) begin
    if (!rstN) seenLo <= 1'b0;
    else if (busValid && busWrite && !busError && busByteEn[0]) seenLo <= 1'b1;
  end

  // R2
  en_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    wdEnable |=> wdEnable);
  // R3
  once_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    seenLo |=> $stable({cfgWaitStop, cfgDebugStop, cfgLowPwrStop}));
  // R5
  wide_no_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busHalfSel && busByteEn == 4'hF) |-> !busError);
  // R6
  err_zero_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    busError |-> busRdata == 32'h0);
  // R6
  err_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    busError |=> $stable({wdEnable, cfgWaitStop, cfgDebugStop, cfgLowPwrStop}));
  // R7
  no_pulse_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wdEnable |=> !timeoutPulse);
  // R8
  kick_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wdKick && wdEnable) |=> !timeoutPulse);
endmodule

bind wd_ctrl_lock wd_ctrl_lock_chk u_chk (.*);

// File: tb/wd_ctrl_lock_tb.sv
`timescale 1ns/1ps
module wd_ctrl_lock_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0, busWrite = 1'b0, busHalfSel = 1'b0;
  logic [3:0]  busByteEn = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        busError;
  logic        wdKick = 1'b0;
  logic        wdEnable, cfgWaitStop, cfgDebugStop, cfgLowPwrStop, timeoutPulse;
  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  wd_ctrl_lock u_dut (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk); rstN = 1'b1;
  endtask

  task automatic access(input logic half, input logic wr, input logic [3:0] be,
                        input logic [31:0] d, output logic [31:0] rd, output logic err);
    @(negedge clk);
    busValid = 1'b1; busWrite = wr; busHalfSel = half; busByteEn = be; busWdata = d;
    #1 rd = busRdata; err = busError;
    @(posedge clk); #1;
    busValid = 1'b0; busWrite = 1'b0; busHalfSel = 1'b0; busByteEn = '0; busWdata = '0;
  endtask

  task automatic readReg(output logic [31:0] rd);
    logic e;
    access(1'b0, 1'b0, 4'hF, 32'h0, rd, e);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic        er;
    doReset();
    // R1 reset state
    @(negedge clk);
    check("R1 outputs", {27'h0, wdEnable, cfgWaitStop, cfgDebugStop, cfgLowPwrStop, timeoutPulse}, 32'h0);
    readReg(rd);
    check("R1 reset read", rd, 32'h0000_FF00);

    // R2 R3 R4 sweep over ordered pairs of low-nibble writes and access sizes
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        int idx = a * 16 + b;
        logic [7:0] tExp, lowExp;
        logic [3:0] be1;
        doReset();
        tExp = 8'hFF;
        if (idx % 2 == 1) begin
          tExp = 8'(idx);
          access(1'b0, 1'b1, 4'b0010, {16'h0, tExp, 8'hFF}, rd, er);
        end
        be1 = (idx % 3 == 0) ? 4'b0001 : (idx % 3 == 1) ? 4'b0011 : 4'b1111;
        access(1'b0, 1'b1, be1, {16'hABCD, tExp, 4'hF, 4'(a)}, rd, er);
        check("R5 no error on first write", {31'h0, er}, 32'h0);
        access(1'b0, 1'b1, 4'b0001, {16'h0, 8'h00, 4'hF, 4'(b)}, rd, er);
        lowExp = {4'h0, a[3], a[2] | b[2], a[1], a[0]};
        readReg(rd);
        check("R2 R3 R4 register", rd, {16'h0, tExp, lowExp});
        @(negedge clk);
        check("R2 R3 outputs", {28'h0, cfgLowPwrStop, wdEnable, cfgDebugStop, cfgWaitStop},
              {28'h0, lowExp[3:0]});
      end
    end

    // R3 read-modify-write consumes the chance; R2 set later still works
    doReset();
    readReg(rd);
    access(1'b0, 1'b1, 4'b0011, rd, rd, er);
    access(1'b0, 1'b1, 4'b0001, 32'h0000_000B, rd, er);
    readReg(rd);
    check("R3 rmw consumed", rd, 32'h0000_FF00);
    access(1'b0, 1'b1, 4'b0001, 32'h0000_0004, rd, er);
    access(1'b0, 1'b1, 4'b0011, 32'h0000_0000, rd, er);
    readReg(rd);
    check("R2 set then clear attempt", rd, 32'h0000_0004);

    // R5 32-bit write folded
    doReset();
    access(1'b0, 1'b1, 4'hF, 32'hFFFF_5AFB, rd, er);
    check("R5 wide write error", {31'h0, er}, 32'h0);
    readReg(rd);
    check("R5 wide read", rd, 32'h0000_5A0B);

    // R6 rejected accesses
    access(1'b1, 1'b1, 4'hF, 32'h0, rd, er);
    check("R6 upper half error", {31'h0, er}, 32'h1);
    access(1'b0, 1'b1, 4'b1100, 32'h0, rd, er);
    check("R6 upper lanes error", {31'h0, er}, 32'h1);
    access(1'b1, 1'b0, 4'hF, 32'h0, rd, er);
    check("R6 error read data", rd, 32'h0);
    readReg(rd);
    check("R6 register unchanged", rd, 32'h0000_5A0B);

    // R7 disabled never pulses
    doReset();
    access(1'b0, 1'b1, 4'b0010, 32'h0000_0200, rd, er);
    begin
      int seen = 0;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (timeoutPulse) seen++;
      end
      check("R7 disabled pulses", 32'(seen), 32'h0);
    end

    // R7 R8 period and kick on the expiry cycle
    doReset();
    access(1'b0, 1'b1, 4'b0010, 32'h0000_0500, rd, er);
    @(negedge clk);
    access(1'b0, 1'b1, 4'b0001, 32'h0000_0004, rd, er);
    for (int k = 1; k <= 31; k++) begin
      logic expP;
      wdKick = (k == 18);
      @(posedge clk);
      @(negedge clk);
      wdKick = 1'b0;
      expP = (k == 6 || k == 12 || k == 24 || k == 30);
      if (k == 18 || k == 24) check("R8 kick at expiry", {31'h0, timeoutPulse}, {31'h0, expP});
      else                    check("R7 pulse timing", {31'h0, timeoutPulse}, {31'h0, expP});
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule